// File: doc/BRIEF.md
# Banked Data-Memory Address Unit

This block turns the data operand of a small 8-bit core into a physical data-memory address and carries out the access in the same cycle. The core names a location with a 5-bit operand. Operands in the lower half of that window are shared by every bank. Operands in the upper half land in one of eight banks, picked by the top three bits of an 8-bit file select register. Operand 00h is a virtual slot: any access that names it goes to the full 8-bit address held in the select register.

The select register itself sits at address 04h. Any data operation can write, clear, increment or bit-modify it, in the same way as a RAM location. A separate bank operation reloads only its three bank bits in one cycle. Read-modify-write operations (increment with zero detect, bit set, bit clear) use a small RAM with an asynchronous read. Each operation therefore finishes in one clock. The block registers the resolved address, a write strobe, the result byte and a skip flag, and shows the select register value at all times.

Top module: `bank_addr_unit`

## Requirements
- R1: While rst is high, on the next clock edge phys_addr, rd_data and fsr_q become 00h, and ram_we and skip become 0.
- R2: A data operation with operand 01h–0Fh resolves to physical address {4'h0, operand[3:0]}, whatever the bank bits hold.
- R3: A data operation with operand 10h–1Fh resolves to {fsr_q[7:5], 1'b1, operand[3:0]}.
- R4: A data operation with operand 00h resolves to the full fsr_q value and acts on the location at that address.
- R5: A resolved address of 04h acts on the select register rather than RAM: fsr_q takes the result, and ram_we stays 0.
- R6: If operand 00h is used while fsr_q is 00h, a read returns 00h, rd_data shows 00h, a write or modify is discarded, ram_we stays 0 and fsr_q keeps its value.
- R7: Opcode 7 (bank) loads bank_sel into fsr_q[7:5] at the next edge. It leaves fsr_q[4:0], phys_addr and rd_data unchanged and gives ram_we 0.
- R8: Opcode 4 (increment) stores the target value plus one, modulo 256. skip is 1 for that one cycle exactly when the stored result is 00h. This applies to the select register too.
- R9: Opcode 5 sets and opcode 6 clears bit bit_sel of the resolved target, including targets reached through operand 00h.
- R10: Opcode 2 stores wr_data and opcode 3 stores 00h. For a RAM target, ram_we is 1 for one cycle after the edge. Opcode 1 returns the stored byte on rd_data.
- R11: Opcode 0 (no operation) leaves fsr_q, phys_addr and rd_data unchanged and gives ram_we 0 and skip 0.

Opcodes 1 to 6 are data operations. After the edge that runs one of them, phys_addr holds the resolved address and rd_data holds the byte the target holds after the operation (for a read, the byte that was read).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 3 | 0 none, 1 read, 2 write, 3 clear, 4 increment, 5 bit set, 6 bit clear, 7 bank |
| opnd | input | 5 | Data operand in the 32-location window |
| wr_data | input | 8 | Byte stored by the write operation |
| bit_sel | input | 3 | Bit position for bit set and bit clear |
| bank_sel | input | 3 | Bank number loaded by the bank operation |
| phys_addr | output | 8 | Resolved physical address of the last data operation |
| ram_we | output | 1 | High for one cycle after a RAM location was written |
| rd_data | output | 8 | Result byte of the last data operation |
| fsr_q | output | 8 | Current file select register value |
| skip | output | 1 | High for one cycle after an increment that wrapped to 00h |

## Verification
The bench uses the default parameters: an 8-bit data path, a 5-bit operand, and three bank bits giving eight banks with no gap bits in the banked address. At that size the increment wraps from FFh to 00h in a couple of steps. The bench can also sweep all eight banks, write a distinct byte into each bank's window and read every byte back through operand 00h. It also reaches the case where the select register points at address 00h or at its own address.

// File: rtl/bank_addr_pkg.sv
package bank_addr_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_READ  = 3'd1,
    OP_WRITE = 3'd2,
    OP_CLR   = 3'd3,
    OP_INC   = 3'd4,
    OP_BSET  = 3'd5,
    OP_BCLR  = 3'd6,
    OP_BANK  = 3'd7
  } op_e;

  function automatic logic is_data_op(op_e op);
    return (op != OP_NOP) && (op != OP_BANK);
  endfunction

  function automatic logic is_modify_op(op_e op);
    return (op == OP_WRITE) || (op == OP_CLR) || (op == OP_INC) ||
           (op == OP_BSET) || (op == OP_BCLR);
  endfunction
endpackage

// File: rtl/fsr_reg.sv
module fsr_reg #(
  parameter int DATA_W = 8,
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_val,
  input  logic              bank_en,
  input  logic [BANK_W-1:0] bank_val,
  output logic [DATA_W-1:0] fsr
);
  localparam int LOW_W = DATA_W - BANK_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      fsr <= '0;
    end else if (bank_en) begin
      fsr[DATA_W-1 -: BANK_W] <= bank_val;
    end else if (wr_en) begin
      fsr <= wr_val;
    end
  end

  // R7
  bank_only_chk: assert property (@(posedge clk) disable iff (rst)
    bank_en |=> (fsr[LOW_W-1:0] == $past(fsr[LOW_W-1:0])) &&
                (fsr[DATA_W-1 -: BANK_W] == $past(bank_val)));
endmodule

// File: rtl/addr_resolve.sv
module addr_resolve #(
  parameter int DATA_W    = 8,
  parameter int OPND_W    = 5,
  parameter int BANK_W    = 3,
  parameter int FSR_ADDR  = 4,
  parameter int INDF_ADDR = 0
) (
  input  logic [OPND_W-1:0] opnd,
  input  logic [DATA_W-1:0] fsr,
  output logic [DATA_W-1:0] tgt_addr,
  output logic              tgt_fsr,
  output logic              tgt_null,
  output logic              indirect
);
  localparam int OFS_W = OPND_W - 1;
  localparam int GAP_W = DATA_W - BANK_W - OPND_W;
  localparam logic [OPND_W-1:0] INDF_OP = OPND_W'(INDF_ADDR);
  localparam logic [DATA_W-1:0] INDF_PHY = DATA_W'(INDF_ADDR);
  localparam logic [DATA_W-1:0] FSR_PHY = DATA_W'(FSR_ADDR);

  logic [DATA_W-1:0] banked_addr;
  logic [DATA_W-1:0] global_addr;

  generate
    if (GAP_W > 0) begin : g_gap
      assign banked_addr = {fsr[DATA_W-1 -: BANK_W], {GAP_W{1'b0}}, 1'b1, opnd[OFS_W-1:0]};
    end else begin : g_nogap
      assign banked_addr = {fsr[DATA_W-1 -: BANK_W], 1'b1, opnd[OFS_W-1:0]};
    end
  endgenerate

  assign global_addr = {{(DATA_W-OFS_W){1'b0}}, opnd[OFS_W-1:0]};

  always_comb begin
    indirect = (opnd == INDF_OP);
    if (indirect)               tgt_addr = fsr;
    else if (opnd[OPND_W-1])    tgt_addr = banked_addr;
    else                        tgt_addr = global_addr;
    tgt_null = indirect && (fsr == INDF_PHY);
    tgt_fsr  = !tgt_null && (tgt_addr == FSR_PHY);
  end
endmodule

// File: rtl/data_ram.sv
module data_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/bank_addr_unit.sv
module bank_addr_unit
  import bank_addr_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int OPND_W    = 5,
  parameter int BANK_W    = 3,
  parameter int FSR_ADDR  = 4,
  parameter int INDF_ADDR = 0,
  localparam int POS_W    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op_code,
  input  logic [OPND_W-1:0] opnd,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [POS_W-1:0]  bit_sel,
  input  logic [BANK_W-1:0] bank_sel,
  output logic [DATA_W-1:0] phys_addr,
  output logic              ram_we,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] fsr_q,
  output logic              skip
);
  localparam logic [DATA_W-1:0] FSR_PHY = DATA_W'(FSR_ADDR);
  localparam logic [DATA_W-1:0] ONE     = DATA_W'(1);

  op_e               op;
  logic [DATA_W-1:0] tgt_addr;
  logic              tgt_fsr, tgt_null, indirect;
  logic [DATA_W-1:0] ram_rdata, cur, nxt, result, bit_mask;
  logic              data_op, mod_op, ram_wr, fsr_wr;

  assign op = op_e'(op_code);

  addr_resolve #(
    .DATA_W(DATA_W), .OPND_W(OPND_W), .BANK_W(BANK_W),
    .FSR_ADDR(FSR_ADDR), .INDF_ADDR(INDF_ADDR)
  ) u_resolve (
    .opnd(opnd), .fsr(fsr_q), .tgt_addr(tgt_addr),
    .tgt_fsr(tgt_fsr), .tgt_null(tgt_null), .indirect(indirect)
  );

  always_comb begin
    data_op  = is_data_op(op);
    mod_op   = is_modify_op(op);
    bit_mask = ONE << bit_sel;
    if (tgt_null)     cur = '0;
    else if (tgt_fsr) cur = fsr_q;
    else              cur = ram_rdata;
    case (op)
      OP_WRITE: nxt = wr_data;
      OP_CLR:   nxt = '0;
      OP_INC:   nxt = cur + ONE;
      OP_BSET:  nxt = cur | bit_mask;
      OP_BCLR:  nxt = cur & ~bit_mask;
      default:  nxt = cur;
    endcase
    result = tgt_null ? '0 : nxt;
    ram_wr = mod_op && !tgt_null && !tgt_fsr;
    fsr_wr = mod_op && tgt_fsr;
  end

  data_ram #(.DATA_W(DATA_W), .ADDR_W(DATA_W)) u_ram (
    .clk(clk), .we(ram_wr), .addr(tgt_addr), .wdata(nxt), .rdata(ram_rdata)
  );

  fsr_reg #(.DATA_W(DATA_W), .BANK_W(BANK_W)) u_fsr (
    .clk(clk), .rst(rst), .wr_en(fsr_wr), .wr_val(nxt),
    .bank_en(op == OP_BANK), .bank_val(bank_sel), .fsr(fsr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_addr <= '0;
      ram_we    <= 1'b0;
      rd_data   <= '0;
      skip      <= 1'b0;
    end else begin
      ram_we <= ram_wr;
      skip   <= (op == OP_INC) && !tgt_null && (nxt == '0);
      if (data_op) begin
        phys_addr <= tgt_addr;
        rd_data   <= result;
      end
    end
  end

  // R4
  indirect_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (data_op && indirect) |=> (phys_addr == $past(fsr_q)));

  // R2
  global_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (data_op && !indirect && !opnd[OPND_W-1]) |=>
      (phys_addr == DATA_W'($past(opnd[OPND_W-2:0]))));

  // R6
  null_discard_chk: assert property (@(posedge clk) disable iff (rst)
    (data_op && tgt_null) |=> (!ram_we && (rd_data == '0) && $stable(fsr_q)));

  // R8
  skip_zero_chk: assert property (@(posedge clk) disable iff (rst)
    skip |-> (rd_data == '0));

  // R5
  fsr_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (phys_addr != FSR_PHY));

  // R11
  nop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_NOP) |=> ($stable(fsr_q) && $stable(phys_addr) && $stable(rd_data) && !ram_we && !skip));
endmodule

// File: tb/tb_bank_addr_unit.sv
module tb_bank_addr_unit;
  localparam logic [2:0] NOP = 3'd0, RD = 3'd1, WR = 3'd2, CL = 3'd3,
                         INC = 3'd4, BS = 3'd5, BC = 3'd6, BK = 3'd7;
  localparam int NV = 28;
  // fields: req, op, opnd, wr_data, bit_sel, bank_sel | addr, we, rd, fsr, skip
  localparam logic [51:0] VEC [NV] = '{
    {4'd10, WR,  5'h05, 8'hA5, 3'd0, 3'd0, 8'h05, 1'b1, 8'hA5, 8'h00, 1'b0}, // R10
    {4'd7,  BK,  5'h00, 8'h00, 3'd0, 3'd3, 8'h05, 1'b0, 8'hA5, 8'h60, 1'b0}, // R7
    {4'd3,  WR,  5'h12, 8'h3C, 3'd0, 3'd0, 8'h72, 1'b1, 8'h3C, 8'h60, 1'b0}, // R3
    {4'd2,  RD,  5'h05, 8'h00, 3'd0, 3'd0, 8'h05, 1'b0, 8'hA5, 8'h60, 1'b0}, // R2
    {4'd7,  BK,  5'h00, 8'h00, 3'd0, 3'd6, 8'h05, 1'b0, 8'hA5, 8'hC0, 1'b0}, // R7
    {4'd3,  WR,  5'h12, 8'h77, 3'd0, 3'd0, 8'hD2, 1'b1, 8'h77, 8'hC0, 1'b0}, // R3
    {4'd7,  BK,  5'h00, 8'h00, 3'd0, 3'd3, 8'hD2, 1'b0, 8'h77, 8'h60, 1'b0}, // R7
    {4'd3,  RD,  5'h12, 8'h00, 3'd0, 3'd0, 8'h72, 1'b0, 8'h3C, 8'h60, 1'b0}, // R3
    {4'd5,  WR,  5'h04, 8'hD2, 3'd0, 3'd0, 8'h04, 1'b0, 8'hD2, 8'hD2, 1'b0}, // R5
    {4'd4,  RD,  5'h00, 8'h00, 3'd0, 3'd0, 8'hD2, 1'b0, 8'h77, 8'hD2, 1'b0}, // R4
    {4'd9,  BS,  5'h00, 8'h00, 3'd3, 3'd0, 8'hD2, 1'b1, 8'h7F, 8'hD2, 1'b0}, // R9
    {4'd9,  BC,  5'h00, 8'h00, 3'd6, 3'd0, 8'hD2, 1'b1, 8'h3F, 8'hD2, 1'b0}, // R9
    {4'd10, WR,  5'h1F, 8'hFE, 3'd0, 3'd0, 8'hDF, 1'b1, 8'hFE, 8'hD2, 1'b0}, // R10
    {4'd8,  INC, 5'h1F, 8'h00, 3'd0, 3'd0, 8'hDF, 1'b1, 8'hFF, 8'hD2, 1'b0}, // R8
    {4'd8,  INC, 5'h1F, 8'h00, 3'd0, 3'd0, 8'hDF, 1'b1, 8'h00, 8'hD2, 1'b1}, // R8
    {4'd8,  INC, 5'h1F, 8'h00, 3'd0, 3'd0, 8'hDF, 1'b1, 8'h01, 8'hD2, 1'b0}, // R8
    {4'd7,  BK,  5'h00, 8'h00, 3'd0, 3'd0, 8'hDF, 1'b0, 8'h01, 8'h12, 1'b0}, // R7
    {4'd5,  CL,  5'h04, 8'h00, 3'd0, 3'd0, 8'h04, 1'b0, 8'h00, 8'h00, 1'b0}, // R5
    {4'd6,  RD,  5'h00, 8'h00, 3'd0, 3'd0, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0}, // R6
    {4'd6,  WR,  5'h00, 8'h55, 3'd0, 3'd0, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0}, // R6
    {4'd5,  INC, 5'h04, 8'h00, 3'd0, 3'd0, 8'h04, 1'b0, 8'h01, 8'h01, 1'b0}, // R5
    {4'd5,  WR,  5'h04, 8'hFF, 3'd0, 3'd0, 8'h04, 1'b0, 8'hFF, 8'hFF, 1'b0}, // R5
    {4'd8,  INC, 5'h04, 8'h00, 3'd0, 3'd0, 8'h04, 1'b0, 8'h00, 8'h00, 1'b1}, // R8
    {4'd11, NOP, 5'h00, 8'h00, 3'd0, 3'd0, 8'h04, 1'b0, 8'h00, 8'h00, 1'b0}, // R11
    {4'd10, RD,  5'h05, 8'h00, 3'd0, 3'd0, 8'h05, 1'b0, 8'hA5, 8'h00, 1'b0}, // R10
    {4'd9,  BS,  5'h04, 8'h00, 3'd7, 3'd0, 8'h04, 1'b0, 8'h80, 8'h80, 1'b0}, // R9
    {4'd4,  WR,  5'h00, 8'h11, 3'd0, 3'd0, 8'h80, 1'b1, 8'h11, 8'h80, 1'b0}, // R4
    {4'd4,  RD,  5'h00, 8'h00, 3'd0, 3'd0, 8'h80, 1'b0, 8'h11, 8'h80, 1'b0}  // R4
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] op_code = '0;
  logic [4:0] opnd = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] bit_sel = '0;
  logic [2:0] bank_sel = '0;
  logic [7:0] phys_addr, rd_data, fsr_q;
  logic       ram_we, skip;
  int         checks = 0;
  int         errors = 0;
  logic       done = 1'b0;

  always #2 clk = ~clk;

  bank_addr_unit dut (
    .clk(clk), .rst(rst), .op_code(op_code), .opnd(opnd), .wr_data(wr_data),
    .bit_sel(bit_sel), .bank_sel(bank_sel), .phys_addr(phys_addr),
    .ram_we(ram_we), .rd_data(rd_data), .fsr_q(fsr_q), .skip(skip)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] o, input logic [4:0] a, input logic [7:0] d,
                        input logic [2:0] b, input logic [2:0] k);
    @(negedge clk);
    op_code = o; opnd = a; wr_data = d; bit_sel = b; bank_sel = k;
    @(posedge clk);
    #1;
  endtask

  task automatic chk_reset(input string tag);
    chk(tag, "phys_addr", phys_addr, 8'h00);
    chk(tag, "ram_we", {7'd0, ram_we}, 8'h00);
    chk(tag, "rd_data", rd_data, 8'h00);
    chk(tag, "fsr_q", fsr_q, 8'h00);
    chk(tag, "skip", {7'd0, skip}, 8'h00);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk_reset("R1");
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [51:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d", v[51:48]);
      run_op(v[47:45], v[44:40], v[39:32], v[31:29], v[28:26]);
      chk(tag, "phys_addr", phys_addr, v[25:18]);
      chk(tag, "ram_we", {7'd0, ram_we}, {7'd0, v[17]});
      chk(tag, "rd_data", rd_data, v[16:9]);
      chk(tag, "fsr_q", fsr_q, v[8:1]);
      chk(tag, "skip", {7'd0, skip}, {7'd0, v[0]});
    end

    // R3: one distinct byte into each bank window at operand 1Ah
    for (int b = 0; b < 8; b++) begin
      run_op(BK, 5'h00, 8'h00, 3'd0, 3'(b));
      run_op(WR, 5'h1A, 8'(b * 3 + 1), 3'd0, 3'd0);
      chk("R3", "bank phys_addr", phys_addr, {3'(b), 5'h1A});
      chk("R3", "bank ram_we", {7'd0, ram_we}, 8'h01);
    end
    // R4: read every bank byte back through the indirect operand
    for (int b = 0; b < 8; b++) begin
      run_op(WR, 5'h04, {3'(b), 5'h1A}, 3'd0, 3'd0);
      run_op(RD, 5'h00, 8'h00, 3'd0, 3'd0);
      chk("R4", "indirect phys_addr", phys_addr, {3'(b), 5'h1A});
      chk("R4", "indirect rd_data", rd_data, 8'(b * 3 + 1));
    end

    // R6: modify through operand 00h while the pointer is 00h changes nothing
    run_op(CL, 5'h04, 8'h00, 3'd0, 3'd0);
    run_op(BS, 5'h00, 8'h00, 3'd2, 3'd0);
    chk("R6", "null bset ram_we", {7'd0, ram_we}, 8'h00);
    chk("R6", "null bset rd_data", rd_data, 8'h00);
    chk("R6", "null bset fsr_q", fsr_q, 8'h00);

    // R1: reset in the middle of a run
    run_op(WR, 5'h04, 8'hB7, 3'd0, 3'd0);
    @(negedge clk);
    rst = 1'b1;
    op_code = NOP;
    @(posedge clk);
    #1;
    chk_reset("R1");
    @(negedge clk);
    rst = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule